// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch stage of a pipelined core and decides, every cycle, which address to fetch next. It keeps a table of 2-bit saturating confidence counters, selected by the low bits of the fetch address. Next to that table it keeps a small direct-mapped cache of taken-branch targets. When the counter says taken and the target cache holds an entry whose tag matches the fetch address, the next fetch address is the cached target. In every other case it is the fetch address plus four. A predicted-taken branch therefore costs no bubble when its target is cached.

The core carries the predicted next address along with the instruction to the decode stage, where the branch is resolved. The core then presents the branch address, the real outcome, the real target and the carried prediction on the resolve port. The block updates the counter and, for a taken branch, the target entry. It raises a flush request with the correct restart address whenever the carried prediction does not match the real path. Different branches may share a counter or a target slot. This changes only how good the predictions are, never whether the program runs correctly. Instruction memory and the branch comparison are outside the block.

Top module: `dirpred_top`

## Requirements
- R1: After reset every counter is in the strongly-not-taken state 00 and every target entry is invalid, so any fetch address gives predTaken=0, predHit=0 and nextPc=fetchPc+4.
- R2: A counter predicts taken exactly when its state is 10 or 11 (upper bit set). One taken outcome from 00 (reaching 01) still predicts not taken, and a second (reaching 10) predicts taken.
- R3: A counter moves one step toward 11 on a taken outcome and one step toward 00 on a not-taken outcome. From 11 a single not-taken outcome still leaves a taken prediction, and a second one flips it to not taken.
- R4: The counter saturates at both ends. Extra taken outcomes at 11 and extra not-taken outcomes at 00 have no effect, so one opposite outcome afterwards does not change the prediction.
- R5: A resolved taken branch writes its target into the target slot chosen by address bits [BTB_BITS+1:2], with the upper address bits as tag, and marks it valid. A later fetch of that address with a taken prediction then gives predHit=1 and nextPc equal to that target.
- R6: When the counter predicts taken but the target slot is invalid or its tag differs from the fetch address, nextPc is fetchPc+4. The counter table is indexed by address bits [BHT_BITS+1:2] only, so addresses 2^(BHT_BITS+2) bytes apart share a counter.
- R7: With resValid high, mispredict is 1 exactly when the real next address (resTarget if resTaken, else resPc+4) differs from resPredNext, and redirectPc equals that real next address.
- R8: With resValid low, mispredict is 0 and neither table changes, whatever the other resolve inputs hold.
- R9: For a backward loop branch taken nine times and then not taken, repeated, the direction prediction is right on 9 of the 10 executions once the first pass is over.
- R10: predHit is 1 exactly when the target slot for fetchPc is valid and its tag matches, whatever the direction prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | AW | Address being fetched this cycle |
| predTaken | output | 1 | Direction prediction for fetchPc |
| predHit | output | 1 | Target cache holds a matching entry for fetchPc |
| nextPc | output | AW | Predicted next fetch address |
| resValid | input | 1 | A branch is resolved in decode this cycle |
| resPc | input | AW | Address of the resolved branch |
| resTaken | input | 1 | Real outcome of the resolved branch |
| resTarget | input | AW | Real target of the resolved branch |
| resPredNext | input | AW | Next address that was predicted for this branch |
| mispredict | output | 1 | Flush the wrong-path fetch and restart |
| redirectPc | output | AW | Correct restart address |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a 64-counter table and a 16-slot target cache. With these sizes, branches 64 bytes apart collide in a target slot and branches 256 bytes apart share a counter. The random branches are drawn from a 1 KB window, so both kinds of sharing, tag mismatches and slot replacement occur often. Directed sequences walk one counter through every state and both saturation points and run the nine-taken loop three times.

// File: rtl/dirpred_pkg.sv
package dirpred_pkg;
  // Strobes from control to datapath for one resolve cycle
  typedef struct packed {
    logic bhtWr;   // update the confidence counter of resPc
    logic btbWr;   // write the target slot of resPc
    logic flush;   // wrong path fetched: request restart
  } updStrobe_t;

  localparam logic [1:0] CNT_INIT = 2'b00;
  localparam logic [1:0] CNT_MAX  = 2'b11;
endpackage

// File: rtl/dirpred_ctrl.sv
module dirpred_ctrl
  import dirpred_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       resValid,
  input  logic       resTaken,
  input  logic       pathMatch,
  output updStrobe_t strb
);
  always_comb begin
    strb.bhtWr = resValid;
    strb.btbWr = resValid && resTaken;
    strb.flush = resValid && !pathMatch;
  end

  // R5: a target write only ever accompanies a counter update
  p_btb_with_bht_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.btbWr |-> strb.bhtWr);

  // R8: no strobe at all without a resolve
  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (strb == '0));
endmodule

// File: rtl/dirpred_dp.sv
module dirpred_dp
  import dirpred_pkg::*;
#(
  parameter int AW       = 32,
  parameter int BHT_BITS = 6,
  parameter int BTB_BITS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] fetchPc,
  input  logic [AW-1:0] resPc,
  input  logic          resTaken,
  input  logic [AW-1:0] resTarget,
  input  logic [AW-1:0] resPredNext,
  input  updStrobe_t    strb,
  output logic          predTaken,
  output logic          predHit,
  output logic [AW-1:0] nextPc,
  output logic          pathMatch,
  output logic [AW-1:0] actualNext
);
  localparam int BHT_N = 1 << BHT_BITS;
  localparam int BTB_N = 1 << BTB_BITS;
  localparam int TAG_W = AW - BTB_BITS - 2;

  logic [1:0]       bht      [BHT_N];
  logic             btbValid [BTB_N];
  logic [TAG_W-1:0] btbTag   [BTB_N];
  logic [AW-1:0]    btbTgt   [BTB_N];

  logic [BHT_BITS-1:0] fIdx, uIdx;
  logic [BTB_BITS-1:0] fSlot, uSlot;
  logic [TAG_W-1:0]    fTag, uTag;
  logic [1:0]          oldCnt, newCnt;
  logic                unusedLowBits;

  assign fIdx  = fetchPc[BHT_BITS+1:2];
  assign uIdx  = resPc[BHT_BITS+1:2];
  assign fSlot = fetchPc[BTB_BITS+1:2];
  assign uSlot = resPc[BTB_BITS+1:2];
  assign fTag  = fetchPc[AW-1:BTB_BITS+2];
  assign uTag  = resPc[AW-1:BTB_BITS+2];
  assign unusedLowBits = ^{fetchPc[1:0], resPc[1:0]};

  // Fetch side
  always_comb begin
    predTaken = bht[fIdx][1];
    predHit   = btbValid[fSlot] && (btbTag[fSlot] == fTag);
    nextPc    = (predTaken && predHit) ? btbTgt[fSlot] : fetchPc + AW'(4);
  end

  // Resolve side
  always_comb begin
    actualNext = resTaken ? resTarget : resPc + AW'(4);
    pathMatch  = (actualNext == resPredNext);
    oldCnt     = bht[uIdx];
    if (resTaken) newCnt = (oldCnt == CNT_MAX) ? CNT_MAX : oldCnt + 2'd1;
    else          newCnt = (oldCnt == CNT_INIT) ? CNT_INIT : oldCnt - 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BHT_N; i++) bht[i] <= CNT_INIT;
    end else if (strb.bhtWr) begin
      bht[uIdx] <= newCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < BTB_N; j++) btbValid[j] <= 1'b0;
    end else if (strb.btbWr) begin
      btbValid[uSlot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.btbWr) begin
      btbTag[uSlot] <= uTag;
      btbTgt[uSlot] <= resTarget;
    end
  end

  // R3: a taken outcome never leaves the counter at 00
  p_up_leaves_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bhtWr && resTaken) |=> (bht[$past(uIdx)] != CNT_INIT));

  // R4: a not-taken outcome never leaves the counter at 11
  p_down_leaves_top_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bhtWr && !resTaken) |=> (bht[$past(uIdx)] != CNT_MAX));

  // R5: a taken resolve leaves its slot valid
  p_slot_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.btbWr |=> btbValid[$past(uSlot)]);

  // R6: without a taken prediction and a hit, fetch goes sequential
  p_seq_fetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(predTaken && predHit) |-> (nextPc == fetchPc + AW'(4)));
endmodule

// File: rtl/dirpred_top.sv
module dirpred_top
  import dirpred_pkg::*;
#(
  parameter int AW       = 32,
  parameter int BHT_BITS = 6,
  parameter int BTB_BITS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] fetchPc,
  output logic          predTaken,
  output logic          predHit,
  output logic [AW-1:0] nextPc,
  input  logic          resValid,
  input  logic [AW-1:0] resPc,
  input  logic          resTaken,
  input  logic [AW-1:0] resTarget,
  input  logic [AW-1:0] resPredNext,
  output logic          mispredict,
  output logic [AW-1:0] redirectPc
);
  updStrobe_t strb;
  logic       pathMatch;

  dirpred_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .resValid  (resValid),
    .resTaken  (resTaken),
    .pathMatch (pathMatch),
    .strb      (strb)
  );

  dirpred_dp #(.AW(AW), .BHT_BITS(BHT_BITS), .BTB_BITS(BTB_BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .fetchPc     (fetchPc),
    .resPc       (resPc),
    .resTaken    (resTaken),
    .resTarget   (resTarget),
    .resPredNext (resPredNext),
    .strb        (strb),
    .predTaken   (predTaken),
    .predHit     (predHit),
    .nextPc      (nextPc),
    .pathMatch   (pathMatch),
    .actualNext  (redirectPc)
  );

  assign mispredict = strb.flush;

  // R7: a flush restarts on the real path of the branch
  p_redirect_path_r7: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> (redirectPc == (resTaken ? resTarget : resPc + AW'(4))));

  // R7: a flush is raised only when the carried prediction was wrong
  p_flush_needs_miss_r7: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> (redirectPc != resPredNext));

  // R8: no flush without a resolve
  p_no_flush_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !mispredict);
endmodule

// File: tb/sim_dirpred_top.sv
module sim_dirpred_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int BHT_BITS = 6;
  localparam int BTB_BITS = 4;
  localparam int BHT_N = 1 << BHT_BITS;
  localparam int BTB_N = 1 << BTB_BITS;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] fetchPc = '0;
  logic          predTaken, predHit, mispredict;
  logic [AW-1:0] nextPc, redirectPc;
  logic          resValid = 1'b0;
  logic [AW-1:0] resPc = '0;
  logic          resTaken = 1'b0;
  logic [AW-1:0] resTarget = '0;
  logic [AW-1:0] resPredNext = '0;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [1:0]    mCnt [BHT_N];
  logic          mVal [BTB_N];
  logic [AW-1:0] mTagPc [BTB_N];
  logic [AW-1:0] mTgt [BTB_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  dirpred_top #(.AW(AW), .BHT_BITS(BHT_BITS), .BTB_BITS(BTB_BITS)) u0 (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predTaken(predTaken),
    .predHit(predHit), .nextPc(nextPc), .resValid(resValid), .resPc(resPc),
    .resTaken(resTaken), .resTarget(resTarget), .resPredNext(resPredNext),
    .mispredict(mispredict), .redirectPc(redirectPc)
  );

  function automatic int bIdx(input logic [AW-1:0] pc);
    return int'(pc[BHT_BITS+1:2]);
  endfunction
  function automatic int tSlot(input logic [AW-1:0] pc);
    return int'(pc[BTB_BITS+1:2]);
  endfunction
  function automatic logic expHit(input logic [AW-1:0] pc);
    return mVal[tSlot(pc)] && (mTagPc[tSlot(pc)][AW-1:BTB_BITS+2] == pc[AW-1:BTB_BITS+2]);
  endfunction
  function automatic logic expTaken(input logic [AW-1:0] pc);
    return mCnt[bIdx(pc)][1];
  endfunction
  function automatic logic [AW-1:0] expNext(input logic [AW-1:0] pc);
    return (expTaken(pc) && expHit(pc)) ? mTgt[tSlot(pc)] : pc + 32'd4;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    resValid = 1'b0;
    for (int i = 0; i < BHT_N; i++) mCnt[i] = 2'b00;
    for (int i = 0; i < BTB_N; i++) begin
      mVal[i] = 1'b0; mTagPc[i] = '0; mTgt[i] = '0;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic checkFetch(input logic [AW-1:0] pc, input string req);
    @(negedge clk);
    fetchPc = pc;
    #1;
    chk(predTaken == expTaken(pc), {req, " predTaken"}, AW'(predTaken), AW'(expTaken(pc)));
    chk(predHit == expHit(pc), {req, " predHit (R10)"}, AW'(predHit), AW'(expHit(pc)));
    chk(nextPc == expNext(pc), {req, " nextPc"}, nextPc, expNext(pc));
  endtask

  task automatic doResolve(input logic [AW-1:0] pc, input logic tk,
                           input logic [AW-1:0] tgt, input logic [AW-1:0] pn,
                           input string req);
    logic [AW-1:0] act;
    @(negedge clk);
    resValid = 1'b1; resPc = pc; resTaken = tk; resTarget = tgt; resPredNext = pn;
    #1;
    act = tk ? tgt : pc + 32'd4;
    chk(mispredict == (act != pn), {req, " mispredict (R7)"}, AW'(mispredict), AW'(act != pn));
    chk(redirectPc == act, {req, " redirectPc (R7)"}, redirectPc, act);
    @(posedge clk);
    if (tk) begin
      mCnt[bIdx(pc)] = (mCnt[bIdx(pc)] == 2'b11) ? 2'b11 : mCnt[bIdx(pc)] + 2'd1;
      mVal[tSlot(pc)] = 1'b1; mTagPc[tSlot(pc)] = pc; mTgt[tSlot(pc)] = tgt;
    end else begin
      mCnt[bIdx(pc)] = (mCnt[bIdx(pc)] == 2'b00) ? 2'b00 : mCnt[bIdx(pc)] - 2'd1;
    end
    #1;
    resValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] pa, pb, tgtA, lp, lt, pc, tg;
    logic tk;
    int correct;
    int unsigned seedVal;
    seedVal = $urandom(32'd20240601);
    pa = 32'h0000_3010; tgtA = 32'h0000_7A00;
    pb = pa + 32'd256;

    applyReset();
    // R1: fresh state
    checkFetch(pa, "R1");
    chk(predTaken == 1'b0 && nextPc == pa + 32'd4, "R1 reset prediction", nextPc, pa + 32'd4);

    // R2: first taken keeps not-taken prediction, second flips it
    doResolve(pa, 1'b1, tgtA, pa + 32'd4, "R2 first taken");
    checkFetch(pa, "R2 after one taken");
    chk(predTaken == 1'b0, "R2 state 01 not taken", AW'(predTaken), 32'd0);
    doResolve(pa, 1'b1, tgtA, pa + 32'd4, "R2 second taken");
    checkFetch(pa, "R5 cached target");
    chk(predTaken && nextPc == tgtA, "R5 zero-penalty target", nextPc, tgtA);

    // R4: saturate at 11, then R3 hysteresis
    doResolve(pa, 1'b1, tgtA, tgtA, "R4 up");
    doResolve(pa, 1'b1, tgtA, tgtA, "R4 up at top");
    doResolve(pa, 1'b1, tgtA, tgtA, "R4 up at top");
    doResolve(pa, 1'b0, tgtA, tgtA, "R3 one not taken");
    checkFetch(pa, "R3 after one wrong");
    chk(predTaken == 1'b1, "R3 still taken", AW'(predTaken), 32'd1);
    doResolve(pa, 1'b0, tgtA, tgtA, "R3 second not taken");
    checkFetch(pa, "R3 after two wrong");
    chk(predTaken == 1'b0, "R3 flipped", AW'(predTaken), 32'd0);
    doResolve(pa, 1'b0, tgtA, pa + 32'd4, "R4 down");
    doResolve(pa, 1'b0, tgtA, pa + 32'd4, "R4 down at floor");
    doResolve(pa, 1'b0, tgtA, pa + 32'd4, "R4 down at floor");
    doResolve(pa, 1'b1, tgtA, pa + 32'd4, "R4 one taken from floor");
    checkFetch(pa, "R4 floor saturated");
    chk(predTaken == 1'b0, "R4 floor holds", AW'(predTaken), 32'd0);

    // R6: shared counter, target slot tag mismatch
    doResolve(pa, 1'b1, tgtA, pa + 32'd4, "R6 train");
    checkFetch(pb, "R6 alias");
    chk(predTaken && !predHit && nextPc == pb + 32'd4, "R6 taken but miss", nextPc, pb + 32'd4);

    // R8: resolve data without resValid changes nothing
    @(negedge clk);
    resValid = 1'b0; resPc = pa; resTaken = 1'b0; resTarget = 32'h0; resPredNext = 32'h5;
    #1;
    chk(mispredict == 1'b0, "R8 no flush when idle", AW'(mispredict), 32'd0);
    repeat (3) @(posedge clk);
    checkFetch(pa, "R8 tables unchanged");

    // R9: nine-taken loop, three passes
    applyReset();
    lp = 32'h0000_1100; lt = 32'h0000_10C0;
    correct = 0;
    for (int pass = 0; pass < 3; pass++) begin
      for (int it = 0; it < 10; it++) begin
        logic [AW-1:0] pn;
        checkFetch(lp, "R9 loop fetch");
        pn = nextPc;
        if (pass == 2 && (predTaken == (it < 9))) correct++;
        doResolve(lp, it < 9, lt, pn, "R9 loop resolve");
      end
    end
    chk(correct == 9, "R9 loop accuracy 9 of 10", AW'(correct), 32'd9);

    // Random traffic over a 1 KB window
    applyReset();
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] pn;
      pc = 32'h0000_4000 + 32'd4 * ($urandom % 256);
      tg = 32'h0000_8000 + 32'd4 * ($urandom % 1024);
      tk = ($urandom % 3) != 0;
      checkFetch(pc, "R5 R6 R10 random fetch");
      pn = nextPc;
      doResolve(pc, tk, tg, pn, "R7 random resolve");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule